// File: doc/BRIEF.md
# Two-Channel Bus Address Break Unit

This unit sits beside a CPU bus and raises an interrupt request when a bus cycle hits a programmed address under a chosen cycle condition. It has two channels built from the same logic. Each channel holds a 24-bit target address and an 8-bit control byte. Software reaches both through a small register port. Every control byte carries a sticky hit flag, an interrupt enable, an address mask code, a cycle-kind selector and a bus-master selector.

A channel checks each bus cycle whose valid strobe is high on a rising clock edge. It compares the address with its target after dropping the low bits named by the mask code. It then checks the cycle kind and the bus master. On a hit it sets its flag. The flag holds until software clears it with a read-then-write sequence: read the control byte and see the flag as 1, then write 0 to the flag. The channel's interrupt output is a registered level that is high while the channel is enabled and flagged.

Register index map on `reg_idx`:

| Index | Register |
|-------|----------|
| 0 | Channel A address |
| 1 | Channel B address |
| 2 | Channel A control |
| 3 | Channel B control |

Top module: `addr_break_unit`

## Requirements
- R1: After reset, both address registers and both control bytes read 0, and `irq` is 0.
- R2: An address register stores bits 23:0 of the write data and reads back all 24 stored bits, including any bits that are masked. Read bits 31:24 are always 0, and written bits 31:24 are dropped.
- R3: Control bits 5:3 hold the mask code. This code sets how many low address bits the compare ignores: code 0 ignores 0 bits, codes 1 to 4 ignore 1 to 4 bits, code 5 ignores 8, code 6 ignores 12 and code 7 ignores 16.
- R4: Control bits 2:1 choose the qualifying cycle kind. `bus_kind` uses 0 for fetch, 1 for data read, 2 for data write and 3 as reserved. Selector 0 accepts fetch only, 1 accepts read only, 2 accepts write only, and 3 accepts read or write.
- R5: With control bit 6 at 0, only CPU cycles (`bus_dma`=0) can hit. With bit 6 at 1, both CPU cycles and transfer-controller cycles (`bus_dma`=1) can hit.
- R6: The flag (control bit 7) sets on the first rising edge where `bus_valid` is 1 and the address, kind and master all qualify. It never sets while `bus_valid` is 0 or while `bus_kind` is 3.
- R7: Software cannot set the flag, because writing 1 to bit 7 has no effect. Writing 0 to bit 7 does not clear the flag unless a clear has been armed.
- R8: A read of a control byte that returns the flag as 1 arms that channel's clear. The next write to that control byte disarms it. If that write has bit 7 at 0, it also clears the flag.
- R9: If a hit occurs in the same cycle as an armed clearing write, the flag stays set.
- R10: `irq[i]` rises one cycle after channel i has both its flag and its enable (control bit 0) set. It falls one cycle after either of them drops.
- R11: The channels are independent. A hit, a configuration change or a clear on one channel does not affect the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; arms the clear when a flag of 1 is read |
| reg_idx | input | 2 | Register index (see map) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_idx` |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 24 | Bus cycle address |
| bus_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write, 3 reserved |
| bus_dma | input | 1 | 0 = CPU cycle, 1 = transfer-controller cycle |
| irq | output | 2 | Interrupt request per channel, bit 0 = channel A |

## Verification
The assertions check the following on every cycle:
- A hit always leaves the flag set on the next edge, and this holds even against an armed clearing write.
- A flag that is neither hit nor armed never changes.
- An `irq` edge only ever follows an enabled, set flag.
- The top byte of an address read is always zero.

Only the bench scenarios can show the rest:
- the exact mask widths at each code's boundary addresses;
- the full pattern of kind, selector and master;
- the read-then-write clear sequence seen from the register port;
- the cycle on which `irq` moves after a hit or a clear.

// File: rtl/abu_pkg.sv
package abu_pkg;

    // Bus cycle kinds presented on bus_kind.
    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_RSVD  = 2'b11
    } bus_kind_e;

    // Qualifying-cycle selector held in the control byte.
    typedef enum logic [1:0] {
        SEL_FETCH = 2'b00,
        SEL_READ  = 2'b01,
        SEL_WRITE = 2'b10,
        SEL_DATA  = 2'b11
    } cond_sel_e;

    // Control byte, most significant field first (bit 7 = flag).
    typedef struct packed {
        logic       flag;
        logic       any_master;
        logic [2:0] mask_code;
        logic [1:0] cond;
        logic       ie;
    } ctrl_t;

    // Number of ignored low address bits for each mask code.
    function automatic int unsigned ignored_bits(input logic [2:0] code);
        case (code)
            3'd0:    ignored_bits = 0;
            3'd1:    ignored_bits = 1;
            3'd2:    ignored_bits = 2;
            3'd3:    ignored_bits = 3;
            3'd4:    ignored_bits = 4;
            3'd5:    ignored_bits = 8;
            3'd6:    ignored_bits = 12;
            default: ignored_bits = 16;
        endcase
    endfunction

endpackage

// File: rtl/abu_mask_decode.sv
// Expands a mask code into a keep-vector: 1 = address bit compared.
module abu_mask_decode #(
    parameter int AW = 24
) (
    input  logic [2:0]    code,
    output logic [AW-1:0] keep
);
    import abu_pkg::*;

    logic [31:0] n_ign;
    assign n_ign = ignored_bits(code);

    for (genvar g = 0; g < AW; g++) begin : g_bit
        assign keep[g] = (n_ign <= 32'(g));
    end

endmodule

// File: rtl/abu_match.sv
// Combinational hit detector for one channel.
module abu_match #(
    parameter int AW = 24
) (
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_kind,
    input  logic          bus_dma,
    input  logic [AW-1:0] target,
    input  logic [2:0]    mask_code,
    input  logic [1:0]    cond,
    input  logic          any_master,
    output logic          hit
);
    import abu_pkg::*;

    logic [AW-1:0] keep;
    logic          addr_ok;
    logic          kind_ok;
    logic          master_ok;
    bus_kind_e     kind;
    cond_sel_e     sel;

    abu_mask_decode #(.AW(AW)) u_mask (
        .code (mask_code),
        .keep (keep)
    );

    always_comb begin
        kind      = bus_kind_e'(bus_kind);
        sel       = cond_sel_e'(cond);
        addr_ok   = ((bus_addr ^ target) & keep) == '0;
        master_ok = !bus_dma || any_master;
        case (sel)
            SEL_FETCH: kind_ok = (kind == KIND_FETCH);
            SEL_READ:  kind_ok = (kind == KIND_READ);
            SEL_WRITE: kind_ok = (kind == KIND_WRITE);
            default:   kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
        endcase
        hit = bus_valid && addr_ok && kind_ok && master_ok;
    end

endmodule

// File: rtl/abu_channel.sv
// One break channel: target register, control byte, clear latch, irq.
module abu_channel #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_ctrl,
    input  logic          rd_ctrl,
    input  logic [AW-1:0] wdata,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_kind,
    input  logic          bus_dma,
    output logic [AW-1:0] addr_q,
    output logic [7:0]    ctrl_q,
    output logic          hit,
    output logic          armed,
    output logic          irq
);
    import abu_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        ctrl_t         ctrl;
        logic          armed;
        logic          irq;
    } state_t;

    state_t s_d, s_q;
    logic   clear_req;

    abu_match #(.AW(AW)) u_match (
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_kind   (bus_kind),
        .bus_dma    (bus_dma),
        .target     (s_q.addr),
        .mask_code  (s_q.ctrl.mask_code),
        .cond       (s_q.ctrl.cond),
        .any_master (s_q.ctrl.any_master),
        .hit        (hit)
    );

    always_comb begin
        s_d       = s_q;
        clear_req = wr_ctrl && !wdata[7] && s_q.armed;

        if (wr_addr) begin
            s_d.addr = wdata;
        end

        if (wr_ctrl) begin
            s_d.ctrl.any_master = wdata[6];
            s_d.ctrl.mask_code  = wdata[5:3];
            s_d.ctrl.cond       = wdata[2:1];
            s_d.ctrl.ie         = wdata[0];
            s_d.armed           = 1'b0;
        end

        // A read that returns the flag as 1 arms the clear.
        if (rd_ctrl && s_q.ctrl.flag) begin
            s_d.armed = 1'b1;
        end

        // A hit outranks a clear in the same cycle.
        if (hit) begin
            s_d.ctrl.flag = 1'b1;
        end else if (clear_req) begin
            s_d.ctrl.flag = 1'b0;
        end

        s_d.irq = s_q.ctrl.ie && s_q.ctrl.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_q = s_q.addr;
    assign ctrl_q = s_q.ctrl;
    assign armed  = s_q.armed;
    assign irq    = s_q.irq;

endmodule

// File: rtl/addr_break_unit.sv
// Top: register decode, read mux and the channel array.
module addr_break_unit #(
    parameter int NUM_CH = 2,
    parameter int AW     = 24,
    parameter int DW     = 32,
    localparam int CHW   = $clog2(NUM_CH),
    localparam int IDXW  = CHW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDXW-1:0]   reg_idx,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              bus_valid,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_dma,
    output logic [NUM_CH-1:0] irq
);

    logic              is_ctrl;
    logic [CHW-1:0]    ch_sel;
    logic [AW-1:0]     addr_v [NUM_CH];
    logic [7:0]        ctrl_v [NUM_CH];
    logic [NUM_CH-1:0] hit_v;
    logic [NUM_CH-1:0] armed_v;
    logic [NUM_CH-1:0] flag_v;
    logic [NUM_CH-1:0] ie_v;
    logic              unused_wdata_hi;

    assign is_ctrl         = reg_idx[IDXW-1];
    assign ch_sel          = reg_idx[CHW-1:0];
    assign unused_wdata_hi = ^reg_wdata[DW-1:AW];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_me;
        assign sel_me = (ch_sel == CHW'(i));

        abu_channel #(.AW(AW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (reg_wr && !is_ctrl && sel_me),
            .wr_ctrl   (reg_wr && is_ctrl && sel_me),
            .rd_ctrl   (reg_rd && is_ctrl && sel_me),
            .wdata     (reg_wdata[AW-1:0]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_kind  (bus_kind),
            .bus_dma   (bus_dma),
            .addr_q    (addr_v[i]),
            .ctrl_q    (ctrl_v[i]),
            .hit       (hit_v[i]),
            .armed     (armed_v[i]),
            .irq       (irq[i])
        );

        assign flag_v[i] = ctrl_v[i][7];
        assign ie_v[i]   = ctrl_v[i][0];
    end

    always_comb begin
        reg_rdata = '0;
        if (is_ctrl) begin
            reg_rdata[7:0] = ctrl_v[ch_sel];
        end else begin
            reg_rdata[AW-1:0] = addr_v[ch_sel];
        end
    end

endmodule

// File: rtl/abu_checker.sv
module abu_checker #(
    parameter int NUM_CH = 2,
    parameter int AW     = 24,
    parameter int DW     = 32,
    parameter int IDXW   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] hit_v,
    input logic [NUM_CH-1:0] flag_v,
    input logic [NUM_CH-1:0] ie_v,
    input logic [NUM_CH-1:0] armed_v,
    input logic [NUM_CH-1:0] irq,
    input logic [IDXW-1:0]   reg_idx,
    input logic [DW-1:AW]    rdata_hi
);

    // R2: top bits of an address read are zero
    a_r2_addr_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_idx[IDXW-1] |-> (rdata_hi == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R6 / R9: a hit always leaves the flag set
        a_r9_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[i] |=> flag_v[i]);

        // R7: an unarmed set flag cannot drop
        a_r7_unarmed_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[i] && !armed_v[i]) |=> flag_v[i]);

        // R7: a clear flag rises only through a hit
        a_r7_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_v[i] && !hit_v[i]) |=> !flag_v[i]);

        // R10: irq rises only after enabled flag
        a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(flag_v[i] && ie_v[i]));

        // R10: enabled flag drives irq next cycle
        a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[i] && ie_v[i]) |=> irq[i]);
    end

endmodule

bind addr_break_unit abu_checker #(
    .NUM_CH (NUM_CH),
    .AW     (AW),
    .DW     (DW),
    .IDXW   (IDXW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_v    (hit_v),
    .flag_v   (flag_v),
    .ie_v     (ie_v),
    .armed_v  (armed_v),
    .irq      (irq),
    .reg_idx  (reg_idx),
    .rdata_hi (reg_rdata[DW-1:AW])
);

// File: tb/addr_break_unit_test.sv
module addr_break_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] IX_ADDR_A = 2'd0;
    localparam logic [1:0] IX_ADDR_B = 2'd1;
    localparam logic [1:0] IX_CTRL_A = 2'd2;
    localparam logic [1:0] IX_CTRL_B = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_kind = '0;
    logic        bus_dma = 1'b0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_break_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_kind  (bus_kind),
        .bus_dma   (bus_dma),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic [1:0] k, input logic m);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_kind = k; bus_dma = m;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] cfg(input logic msel, input logic [2:0] mask,
                                        input logic [1:0] cond, input logic ie);
        return {24'h0, 1'b0, msel, mask, cond, ie};
    endfunction

    function automatic int ign(input int code);
        return (code <= 4) ? code : (code == 5) ? 8 : (code == 6) ? 12 : 16;
    endfunction

    // Read control byte, compare flag, then rewrite config with bit 7 = 0.
    task automatic flag_is(input int ch, input logic exp, input string req);
        logic [31:0] d;
        rd(ch == 0 ? IX_CTRL_A : IX_CTRL_B, d);
        check(req, {31'h0, d[7]}, {31'h0, exp});
        wr(ch == 0 ? IX_CTRL_A : IX_CTRL_B, d & 32'h7F);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", {30'h0, irq}, 32'h0);
    endtask

    task automatic t_addr_reg();
        logic [31:0] d;
        wr(IX_ADDR_A, 32'hFFAB_CDEF);
        wr(IX_ADDR_B, 32'h1234_5678);
        rd(IX_ADDR_A, d);
        check("R2 addr A readback", d, 32'h00AB_CDEF);
        rd(IX_ADDR_B, d);
        check("R2 addr B readback", d, 32'h0034_5678);
        wr(IX_CTRL_A, cfg(1'b0, 3'd7, 2'd0, 1'b0));
        rd(IX_ADDR_A, d);
        check("R2 masked bits kept", d, 32'h00AB_CDEF);
    endtask

    task automatic t_mask();
        logic [23:0] base = 24'h5A_C3_E7;
        for (int c = 0; c < 8; c++) begin
            int n = ign(c);
            logic [23:0] keep = ~((24'h1 << n) - 24'h1);
            wr(IX_ADDR_A, {8'h0, base});
            wr(IX_CTRL_A, cfg(1'b0, 3'(c), 2'd0, 1'b0));
            bus(base & keep, 2'd0, 1'b0);
            flag_is(0, 1'b1, "R3 low edge");
            bus(base | ~keep, 2'd0, 1'b0);
            flag_is(0, 1'b1, "R3 high edge");
            bus(base ^ (24'h1 << n), 2'd0, 1'b0);
            flag_is(0, 1'b0, "R3 first kept bit");
        end
    endtask

    task automatic t_cond();
        wr(IX_ADDR_A, 32'h0000_1234);
        for (int c = 0; c < 4; c++)
            for (int ms = 0; ms < 2; ms++)
                for (int k = 0; k < 4; k++)
                    for (int m = 0; m < 2; m++) begin
                        logic kind_ok, exp;
                        kind_ok = (c == 0) ? (k == 0) : (c == 1) ? (k == 1) :
                                  (c == 2) ? (k == 2) : (k == 1 || k == 2);
                        exp = kind_ok && (m == 0 || ms == 1);
                        wr(IX_CTRL_A, cfg(1'(ms), 3'd0, 2'(c), 1'b0));
                        bus(24'h001234, 2'(k), 1'(m));
                        flag_is(0, exp, "R4 R5 R6 kind/master");
                    end
        // No valid strobe: no hit
        wr(IX_CTRL_A, cfg(1'b1, 3'd0, 2'd3, 1'b0));
        @(negedge clk);
        bus_addr = 24'h001234; bus_kind = 2'd1; bus_dma = 1'b0;
        @(negedge clk);
        flag_is(0, 1'b0, "R6 valid low");
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(IX_ADDR_A, 32'h0000_4000);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0) | 32'h80);
        rd(IX_CTRL_A, d);
        check("R7 write 1 no set", {31'h0, d[7]}, 32'h0);
        bus(24'h004000, 2'd0, 1'b0);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0));
        rd(IX_CTRL_A, d);
        check("R7 clear without read", {31'h0, d[7]}, 32'h1);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0));
        rd(IX_CTRL_A, d);
        check("R8 clear after read", {31'h0, d[7]}, 32'h0);
        bus(24'h004000, 2'd0, 1'b0);
        rd(IX_CTRL_A, d);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0) | 32'h80);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0));
        rd(IX_CTRL_A, d);
        check("R8 disarmed by write", {31'h0, d[7]}, 32'h1);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0));
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(IX_ADDR_A, 32'h0000_8000);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd2, 1'b0));
        bus(24'h008000, 2'd2, 1'b0);
        rd(IX_CTRL_A, d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = IX_CTRL_A; reg_wdata = cfg(1'b0, 3'd0, 2'd2, 1'b0);
        bus_valid = 1'b1; bus_addr = 24'h008000; bus_kind = 2'd2; bus_dma = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; bus_valid = 1'b0;
        rd(IX_CTRL_A, d);
        check("R9 hit beats clear", {31'h0, d[7]}, 32'h1);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd2, 1'b0));
        flag_is(0, 1'b0, "R9 later clear");
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(IX_ADDR_A, 32'h0000_0100);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b1));
        bus(24'h000100, 2'd0, 1'b0);
        check("R10 irq not same cycle", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle later", {31'h0, irq[0]}, 32'h1);
        rd(IX_CTRL_A, d);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b1));
        check("R10 irq holds at clear edge", {31'h0, irq[0]}, 32'h1);
        @(negedge clk);
        check("R10 irq falls after clear", {31'h0, irq[0]}, 32'h0);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b0));
        bus(24'h000100, 2'd0, 1'b0);
        @(negedge clk);
        check("R10 disabled no irq", {31'h0, irq[0]}, 32'h0);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b1));
        check("R10 enable edge", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        check("R10 irq after late enable", {31'h0, irq[0]}, 32'h1);
        flag_is(0, 1'b1, "R10 flag kept");
        wr(IX_CTRL_A, 32'h0);
    endtask

    task automatic t_indep();
        wr(IX_ADDR_A, 32'h0000_0A00);
        wr(IX_ADDR_B, 32'h0000_0B00);
        wr(IX_CTRL_A, cfg(1'b0, 3'd0, 2'd0, 1'b1));
        wr(IX_CTRL_B, cfg(1'b0, 3'd0, 2'd0, 1'b1));
        bus(24'h000A00, 2'd0, 1'b0);
        @(negedge clk);
        check("R11 only A irq", {30'h0, irq}, 32'h1);
        flag_is(1, 1'b0, "R11 B untouched");
        flag_is(0, 1'b1, "R11 A flagged");
        bus(24'h000B00, 2'd0, 1'b0);
        @(negedge clk);
        check("R11 only B irq", {30'h0, irq}, 32'h2);
        flag_is(1, 1'b1, "R11 B flagged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_reg();
        t_mask();
        t_cond();
        t_clear();
        t_race();
        t_irq();
        t_indep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule